// File: doc/BRIEF.md
# Command-Driven Slow-Word Deserializer

This block sits at the receive end of a host-to-board serial link and runs on the recovered link clock. A frame arrives as a single cycle with `frameValid` high. Each frame carries a 2-bit command, a 2-bit fragment of a long configuration word, and an 8-bit value for the board's digital output lines. The block assembles the configuration word two bits per frame in a 48-bit shift register. A validate command commits the assembled word to a held register, and the same frame's fragment becomes the first fragment of the next word.

The held word is split into named fields that downstream logic reads directly: run state, reset-done, LED level and mode, four 2-bit port status codes, analog and GPIO direction masks, and a sync configuration pair. A one-cycle pulse marks each commit. The digital output lines take the value carried by every frame, whatever command that frame carries.

Top module: `slow_word_rx`

## Requirements
- R1: After the hardware reset, `heldWord` and `digOut` are zero and `commitPulse` is low. The hidden shift register is also zero, so a validate command sent before any shift commits all zeros.
- R2: Command code 2'b00 moves the shift register up by two places. The two most significant bits are discarded. `fragIn[1]` enters at bit 1 and `fragIn[0]` at bit 0. `heldWord` does not change.
- R3: Command code 2'b10 behaves exactly like 2'b00.
- R4: Command code 2'b01 copies the shift register as it stood before the frame into `heldWord`, visible from the next cycle. It also loads the shift register with zeros except bits 1:0, which take `fragIn`.
- R5: `commitPulse` is high for exactly the one cycle after each 2'b01 frame, and low at all other times.
- R6: Command code 2'b11 clears both the shift register and `heldWord` to zero and raises no `commitPulse`.
- R7: `digOut` takes `doutIn` on every valid frame, whatever the command, and holds its value between frames.
- R8: While `frameValid` is low, `heldWord`, `digOut` and the shift register do not change, and `commitPulse` stays low.
- R9: The field outputs are slices of `heldWord`, counted from the LSB. Bit 0 is the run state and bit 1 is reset-done. Bits 3:2 are reserved. LED level is bits 7:4 and LED mode is bits 9:8. Port status for ports 0 to 3 is bits 11:10, 13:12, 15:14 and 17:16, placed at `portStatus[2i+1:2i]`; each code reads 00 off, 01 powered, 10 locked, 11 map good. Analog direction is bits 29:18, sync configuration is bits 31:30 and GPIO direction is bits 47:32.
- R10: Twenty-four shift frames sent most significant fragment first, followed by a validate, commit the whole 48-bit word. When more than 24 fragments arrive before a validate, only the last 24 remain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered link clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameValid | input | 1 | Marks a cycle that carries a frame |
| cmdIn | input | 2 | Frame command code |
| fragIn | input | 2 | Slow-word fragment |
| doutIn | input | 8 | Digital output value carried by the frame |
| digOut | output | 8 | Digital output lines, 1 = high |
| heldWord | output | 48 | Last committed slow word |
| commitPulse | output | 1 | One-cycle strobe after each commit |
| runState | output | 1 | Host run state |
| resetDone | output | 1 | Host reset complete |
| ledLevel | output | 4 | LED brightness level |
| ledMode | output | 2 | LED display mode |
| portStatus | output | 8 | Four 2-bit port status codes |
| analogDir | output | 12 | Analog channel direction mask |
| syncCfg | output | 2 | Sync configuration |
| gpioDir | output | 16 | GPIO direction mask |

## Verification
The shift register has no port of its own, so the bench can only observe it through a later validate. The hardest states to reach are therefore those where the register holds a word seeded by an earlier validate, or has overflowed past 24 fragments, or has been interrupted by reserved-code frames. The bench reaches them with directed sequences: a seed followed by 23 shifts, and 30 shifts before a commit. It then runs a long pseudo-random stream of all four commands, with idle gaps, against an arithmetic model of the register. Every later commit exposes the model's value at the ports.

// File: rtl/swr_pkg.sv
package swr_pkg;

  typedef enum logic [1:0] {
    CMD_SHIFT     = 2'b00,
    CMD_COMMIT    = 2'b01,
    CMD_SHIFT_ALT = 2'b10,
    CMD_CLEAR     = 2'b11
  } cmdCode_e;

  typedef struct packed {
    logic outEn;
    logic shiftEn;
    logic commitEn;
    logic clearEn;
  } dpStrobe_t;

  localparam int SLOW_W      = 48;
  localparam int RUN_BIT     = 0;
  localparam int RSTDONE_BIT = 1;
  localparam int LVL_LSB     = 4;
  localparam int LVL_W       = 4;
  localparam int MODE_LSB    = 8;
  localparam int MODE_W      = 2;
  localparam int PORT_LSB    = 10;
  localparam int PORT_W      = 2;
  localparam int ANA_LSB     = 18;
  localparam int ANA_W       = 12;
  localparam int SYNC_LSB    = 30;
  localparam int SYNC_W      = 2;
  localparam int GPIO_LSB    = 32;
  localparam int GPIO_W      = 16;

endpackage

// File: rtl/swr_ctrl.sv
module swr_ctrl
  import swr_pkg::*;
(
  input  logic       frameValid,
  input  logic [1:0] cmdIn,
  output dpStrobe_t  strobe
);

  cmdCode_e cmdCode;
  assign cmdCode = cmdCode_e'(cmdIn);

  always_comb begin
    strobe = '0;
    if (frameValid) begin
      strobe.outEn = 1'b1;
      unique case (cmdCode)
        CMD_SHIFT, CMD_SHIFT_ALT: strobe.shiftEn  = 1'b1;
        CMD_COMMIT:               strobe.commitEn = 1'b1;
        CMD_CLEAR:                strobe.clearEn  = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/swr_datapath.sv
module swr_datapath
  import swr_pkg::*;
#(
  parameter int WORD_W = 48,
  parameter int FRAG_W = 2,
  parameter int DOUT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [FRAG_W-1:0] fragIn,
  input  logic [DOUT_W-1:0] doutIn,
  output logic [WORD_W-1:0] shiftWord,
  output logic [WORD_W-1:0] heldWord,
  output logic [DOUT_W-1:0] digOut,
  output logic              commitPulse
);

  localparam int KEEP_W = WORD_W - FRAG_W;

  logic [WORD_W-1:0] shiftNext;
  logic [WORD_W-1:0] seedWord;

  assign seedWord  = WORD_W'(fragIn);
  assign shiftNext = {shiftWord[KEEP_W-1:0], fragIn};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftWord   <= '0;
      heldWord    <= '0;
      digOut      <= '0;
      commitPulse <= 1'b0;
    end else begin
      commitPulse <= strobe.commitEn;
      if (strobe.outEn) digOut <= doutIn;
      if (strobe.clearEn) begin
        shiftWord <= '0;
        heldWord  <= '0;
      end else if (strobe.commitEn) begin
        heldWord  <= shiftWord;
        shiftWord <= seedWord;
      end else if (strobe.shiftEn) begin
        shiftWord <= shiftNext;
      end
    end
  end

endmodule

// File: rtl/slow_word_rx.sv
module slow_word_rx
  import swr_pkg::*;
#(
  parameter int DOUT_W = 8,
  parameter int NPORT  = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    frameValid,
  input  logic [1:0]              cmdIn,
  input  logic [1:0]              fragIn,
  input  logic [DOUT_W-1:0]       doutIn,
  output logic [DOUT_W-1:0]       digOut,
  output logic [SLOW_W-1:0]       heldWord,
  output logic                    commitPulse,
  output logic                    runState,
  output logic                    resetDone,
  output logic [LVL_W-1:0]        ledLevel,
  output logic [MODE_W-1:0]       ledMode,
  output logic [NPORT*PORT_W-1:0] portStatus,
  output logic [ANA_W-1:0]        analogDir,
  output logic [SYNC_W-1:0]       syncCfg,
  output logic [GPIO_W-1:0]       gpioDir
);

  localparam int FRAG_W = 2;

  dpStrobe_t         strobe;
  logic [SLOW_W-1:0] shiftWord;

  swr_ctrl u_ctrl (
    .frameValid(frameValid),
    .cmdIn     (cmdIn),
    .strobe    (strobe)
  );

  swr_datapath #(
    .WORD_W(SLOW_W),
    .FRAG_W(FRAG_W),
    .DOUT_W(DOUT_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .fragIn     (fragIn),
    .doutIn     (doutIn),
    .shiftWord  (shiftWord),
    .heldWord   (heldWord),
    .digOut     (digOut),
    .commitPulse(commitPulse)
  );

  assign runState  = heldWord[RUN_BIT];
  assign resetDone = heldWord[RSTDONE_BIT];
  assign ledLevel  = heldWord[LVL_LSB +: LVL_W];
  assign ledMode   = heldWord[MODE_LSB +: MODE_W];
  assign analogDir = heldWord[ANA_LSB +: ANA_W];
  assign syncCfg   = heldWord[SYNC_LSB +: SYNC_W];
  assign gpioDir   = heldWord[GPIO_LSB +: GPIO_W];

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign portStatus[p*PORT_W +: PORT_W] = heldWord[PORT_LSB + p*PORT_W +: PORT_W];
  end

endmodule

// File: rtl/swr_checker.sv
module swr_checker #(
  parameter int WORD_W = 48,
  parameter int DOUT_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              frameValid,
  input logic [1:0]        cmdIn,
  input logic [1:0]        fragIn,
  input logic [DOUT_W-1:0] doutIn,
  input logic [DOUT_W-1:0] digOut,
  input logic [WORD_W-1:0] heldWord,
  input logic [WORD_W-1:0] shiftWord,
  input logic              commitPulse
);

  // R2 R3
  held_on_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && !cmdIn[0]) |=> $stable(heldWord));

  // R4
  commit_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && cmdIn == 2'b01) |=> (heldWord == $past(shiftWord)
                                        && shiftWord == WORD_W'($past(fragIn))));

  // R5
  pulse_after_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && cmdIn == 2'b01) |=> commitPulse);

  // R5
  pulse_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(commitPulse) |-> $past(frameValid && cmdIn == 2'b01));

  // R6
  clear_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && cmdIn == 2'b11) |=> (heldWord == '0 && shiftWord == '0 && !commitPulse));

  // R7
  dout_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameValid |=> digOut == $past(doutIn));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !frameValid |=> ($stable(heldWord) && $stable(digOut) && $stable(shiftWord) && !commitPulse));

endmodule

bind slow_word_rx swr_checker #(
  .WORD_W(swr_pkg::SLOW_W),
  .DOUT_W(DOUT_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .frameValid (frameValid),
  .cmdIn      (cmdIn),
  .fragIn     (fragIn),
  .doutIn     (doutIn),
  .digOut     (digOut),
  .heldWord   (heldWord),
  .shiftWord  (shiftWord),
  .commitPulse(commitPulse)
);

// File: tb/tb_slow_word_rx.sv
`timescale 1ns/1ps
module tb_slow_word_rx;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameValid = 1'b0;
  logic [1:0]  cmdIn = 2'b00;
  logic [1:0]  fragIn = 2'b00;
  logic [7:0]  doutIn = 8'h00;
  logic [7:0]  digOut;
  logic [47:0] heldWord;
  logic        commitPulse;
  logic        runState, resetDone;
  logic [3:0]  ledLevel;
  logic [1:0]  ledMode, syncCfg;
  logic [7:0]  portStatus;
  logic [11:0] analogDir;
  logic [15:0] gpioDir;

  int checks = 0;
  int errors = 0;
  logic [47:0] expShift = '0;
  logic [47:0] expHeld = '0;
  logic [7:0]  expDout = '0;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  slow_word_rx dut (
    .clk(clk), .rstN(rstN), .frameValid(frameValid), .cmdIn(cmdIn),
    .fragIn(fragIn), .doutIn(doutIn), .digOut(digOut), .heldWord(heldWord),
    .commitPulse(commitPulse), .runState(runState), .resetDone(resetDone),
    .ledLevel(ledLevel), .ledMode(ledMode), .portStatus(portStatus),
    .analogDir(analogDir), .syncCfg(syncCfg), .gpioDir(gpioDir)
  );

  task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string cmdTag(input logic [1:0] c);
    case (c)
      2'b00:   return "R2 shift";
      2'b10:   return "R3 reserved";
      2'b01:   return "R4 commit";
      default: return "R6 clear";
    endcase
  endfunction

  task automatic sendFrame(input logic [1:0] c, input logic [1:0] f, input logic [7:0] d);
    frameValid = 1'b1; cmdIn = c; fragIn = f; doutIn = d;
    case (c)
      2'b01: begin expHeld = expShift; expShift = {46'b0, f}; end
      2'b11: begin expHeld = '0; expShift = '0; end
      default: expShift = {expShift[45:0], f};
    endcase
    expDout = d;
    @(posedge clk);
    @(negedge clk);
    chk(cmdTag(c), heldWord, expHeld);
    chk("R7 dout", {40'b0, digOut}, {40'b0, expDout});
    chk("R5 pulse", {47'b0, commitPulse}, {47'b0, c == 2'b01});
    frameValid = 1'b0;
  endtask

  task automatic idle(input int n);
    frameValid = 1'b0;
    cmdIn = 2'b01; fragIn = 2'b11; doutIn = ~expDout;
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R8 idle pulse", {47'b0, commitPulse}, 48'b0);
    end
    chk("R8 idle held", heldWord, expHeld);
    chk("R8 idle dout", {40'b0, digOut}, {40'b0, expDout});
  endtask

  task automatic checkFields(input logic [47:0] w);
    chk("R9 run", {47'b0, runState}, {47'b0, w[0]});
    chk("R9 rstdone", {47'b0, resetDone}, {47'b0, w[1]});
    chk("R9 level", {44'b0, ledLevel}, {44'b0, w[7:4]});
    chk("R9 mode", {46'b0, ledMode}, {46'b0, w[9:8]});
    for (int p = 0; p < 4; p++)
      chk("R9 port", {46'b0, portStatus[2*p +: 2]}, {46'b0, w[10 + 2*p +: 2]});
    chk("R9 analog", {36'b0, analogDir}, {36'b0, w[29:18]});
    chk("R9 sync", {46'b0, syncCfg}, {46'b0, w[31:30]});
    chk("R9 gpio", {32'b0, gpioDir}, {32'b0, w[47:32]});
  endtask

  task automatic loadWord(input logic [47:0] w, input int extra);
    for (int k = 0; k < extra; k++) sendFrame(2'b00, 2'(k), 8'(k));
    for (int k = 23; k >= 0; k--) sendFrame((k % 3 == 0) ? 2'b10 : 2'b00, w[2*k +: 2], 8'(k * 7));
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 held", heldWord, 48'b0);
    chk("R1 dout", {40'b0, digOut}, 48'b0);
    chk("R1 pulse", {47'b0, commitPulse}, 48'b0);
    rstN = 1'b1;
    @(negedge clk);
    sendFrame(2'b01, 2'b00, 8'h5A);
    chk("R1 empty shift", heldWord, 48'b0);

    // R10 full word, MSB fragment first
    sendFrame(2'b11, 2'b00, 8'h00);
    loadWord(48'hA5C3_9E17_6B2D, 0);
    sendFrame(2'b01, 2'b10, 8'hC3);
    chk("R10 full word", heldWord, 48'hA5C3_9E17_6B2D);
    checkFields(48'hA5C3_9E17_6B2D);
    idle(4);

    // R4 seed: the commit fragment lands at the top after 23 more shifts
    for (int k = 22; k >= 0; k--) sendFrame(2'b00, 2'(k), 8'h11);
    sendFrame(2'b01, 2'b01, 8'h22);
    chk("R4 seed at top", {46'b0, heldWord[47:46]}, 48'd2);

    // R10 overflow: 30 fragments, last 24 kept
    sendFrame(2'b11, 2'b11, 8'h33);
    loadWord(48'h1234_5678_9ABC, 6);
    sendFrame(2'b01, 2'b00, 8'h44);
    chk("R10 overflow", heldWord, 48'h1234_5678_9ABC);
    checkFields(48'h1234_5678_9ABC);

    // R6 clear then field zero
    sendFrame(2'b11, 2'b01, 8'h55);
    checkFields(48'h0);

    // Sweep all commands, fragments and gaps
    for (int n = 0; n < 3000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[7:4] == 4'h0) idle(1 + int'(lfsr[9:8]));
      else sendFrame((lfsr[3:2] == 2'b11 && lfsr[11]) ? 2'b00 : lfsr[3:2], lfsr[1:0], lfsr[15:8]);
    end
    checkFields(expHeld);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule